// File: doc/BRIEF.md
# Round-Robin Bus Grant Arbiter

This block is the central grant logic for a shared, synchronous parallel bus with several masters. Each master has its own request line into the arbiter and its own grant line back from it. The arbiter samples every request on each rising clock edge and keeps at most one grant active. It also watches two bus status inputs: whether a transaction frame is open and whether the initiator is signalling ready. When both are low, the bus is idle.

The grant is registered. It can move to the next requester while the current owner's transaction is still running, so the next master is already waiting when the bus goes idle. A newly granted master is protected until it starts a transaction. Once it has started, or has dropped its request, any other requester takes the grant in round-robin order. If nobody requests, the grant stays parked on the last owner. If a protected grantee keeps requesting through a set number of idle clocks without starting, its grant is taken away.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is low, and after release with no requests, no grant bit is set.
- R2: At most one bit of `award` is high in any cycle. A change of owner between two requesters takes effect on a single edge, with no cycle of zero grant in between.
- R3: A decision uses the inputs sampled at a rising edge and shows on `award` right after that edge. With no grant held, a request seen at an edge is granted at that same edge.
- R4: When the grant is free to move, the new owner is the first requesting master found by counting upward from the current owner's index + 1 and wrapping past NM-1 to 0. After reset the current-owner index is NM-1, so master 0 is checked first.
- R5: A transaction start is an edge where `cycle_on` is high, some grant is held, and the previous edge saw the bus idle (`cycle_on` and `xfer_rdy` both low). From that edge on, another pending request moves the grant, even while `cycle_on` or `xfer_rdy` are still high.
- R6: A grant is fresh from the edge it is given to a master that did not already hold it, until a transaction start. While the owner's grant is fresh and the owner keeps requesting, other requests do not move the grant.
- R7: An owner that drops its request loses the grant at that edge to the round-robin pick, if any other master is requesting.
- R8: With no request at all, `award` holds its value (the last owner stays parked, or no grant stays no grant).
- R9: An owner that keeps requesting after its transaction start stays eligible. It keeps the grant while it is the only requester, and it is not protected against other requesters.
- R10: If the owner's grant is fresh, the owner keeps requesting, and IDLE_LIMIT idle edges have been seen since the grant, the grant is withdrawn at that IDLE_LIMIT-th idle edge. It goes to the round-robin pick among the other requesters, or to no grant if none is requesting.
- R11: Edges where the bus is busy (`cycle_on` or `xfer_rdy` high) do not count toward the IDLE_LIMIT window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bid | input | NM | Per-master request, active high |
| cycle_on | input | 1 | High while a transaction frame is open |
| xfer_rdy | input | 1 | High while the initiator signals ready for a data phase |
| award | output | NM | Per-master grant, active high, at most one set |

## Verification
The bench is built around the edge where a master starts its transaction. An arbiter that rotates on any request steals a fresh grant before the master can use it. One that waits for idle before rotating loses the hidden hand-over while the frame is still open. The timeout window is probed with busy cycles placed inside it: a counter that also counts busy clocks withdraws grants from masters that were only waiting for the bus. Wrap-around at the last index, withdrawal with no other requester (grant goes to zero, then is re-issued), and a sole requester that stays after its start are all driven. An off-by-one in the scan or the counter moves the grant one master or one cycle early or late.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int NM         = 4,
  parameter int IDLE_LIMIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] bid,
  input  logic          cycle_on,
  input  logic          xfer_rdy,
  output logic [NM-1:0] award
);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;
  localparam int CW = $clog2(IDLE_LIMIT + 1);

  logic [IW-1:0] owner;
  logic          held, used, prev_idle;
  logic [CW-1:0] wait_cnt;

  logic idle, start, used_now, own_bid, timeout, release_ok;
  logic [IW-1:0] pick_any, pick_other;
  logic          any_hit, other_hit;

  assign idle       = !cycle_on && !xfer_rdy;
  assign start      = held && cycle_on && prev_idle;
  assign used_now   = used || start;
  assign own_bid    = bid[owner];
  assign timeout    = held && !used_now && own_bid && idle &&
                      (wait_cnt == CW'(IDLE_LIMIT - 1));
  assign release_ok = !held || !own_bid || used_now;

  always_comb begin
    pick_any   = owner;
    pick_other = owner;
    any_hit    = 1'b0;
    other_hit  = 1'b0;
    for (int off = NM; off >= 1; off--) begin
      if (bid[IW'((int'(owner) + off) % NM)]) begin
        pick_any = IW'((int'(owner) + off) % NM);
        any_hit  = 1'b1;
        if (off != NM) begin
          pick_other = IW'((int'(owner) + off) % NM);
          other_hit  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner     <= IW'(NM - 1);
      held      <= 1'b0;
      used      <= 1'b0;
      wait_cnt  <= '0;
      prev_idle <= 1'b1;
    end else begin
      prev_idle <= idle;
      if (timeout) begin
        wait_cnt <= '0;
        used     <= 1'b0;
        held     <= other_hit;
        if (other_hit) owner <= pick_other;
      end else if (release_ok && any_hit) begin
        owner    <= pick_any;
        held     <= 1'b1;
        wait_cnt <= '0;
        used     <= (held && pick_any == owner) ? used_now : 1'b0;
      end else if (release_ok) begin
        used     <= used_now;
        wait_cnt <= '0;
      end else begin
        used <= used_now;
        if (idle) wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  assign award = held ? (NM'(1) << owner) : '0;
endmodule

module bus_arbiter_chk #(
  parameter int NM         = 4,
  parameter int IDLE_LIMIT = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] bid,
  input logic [NM-1:0] award,
  input logic          idle,
  input logic          used,
  input logic          start,
  input logic [$clog2(IDLE_LIMIT+1)-1:0] wait_cnt
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(award));

  p_new_owner_requested_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|award && award != $past(award)) |-> |($past(bid) & award));

  p_fresh_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(award & bid) && !used && !start && !(idle && wait_cnt == CW'(IDLE_LIMIT - 1)))
      |=> $stable(award));

  p_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bid == '0) |=> $stable(award));

  p_withdraw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(award & bid) && !used && !start && idle && wait_cnt == CW'(IDLE_LIMIT - 1))
      |=> (award != $past(award)));
endmodule

bind bus_arbiter bus_arbiter_chk #(.NM(NM), .IDLE_LIMIT(IDLE_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bid(bid), .award(award), .idle(idle),
  .used(used), .start(start), .wait_cnt(wait_cnt)
);

// File: tb/bus_arbiter_test.sv
module bus_arbiter_test;
  localparam int NM  = 4;
  localparam int LIM = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM-1:0] bid = '0;
  logic          cycle_on = 1'b0;
  logic          xfer_rdy = 1'b0;
  logic [NM-1:0] award;

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;

  bus_arbiter #(.NM(NM), .IDLE_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .bid(bid), .cycle_on(cycle_on),
    .xfer_rdy(xfer_rdy), .award(award)
  );

  always #10 clk = ~clk;

  // behavioural reference
  int    m_own, m_held, m_used, m_cnt, m_pidle;
  int    m_any, m_oth, m_cand;
  bit    m_idle, m_start, m_usedn, m_obid;
  string m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = NM - 1; m_held = 0; m_used = 0; m_cnt = 0; m_pidle = 1; m_tag = "R1";
    end else begin
      m_idle  = !cycle_on && !xfer_rdy;
      m_start = (m_held != 0) && cycle_on && (m_pidle != 0);
      m_usedn = (m_used != 0) || m_start;
      m_obid  = bid[m_own];
      m_any = -1; m_oth = -1;
      for (int k = 1; k <= NM; k++) begin
        m_cand = (m_own + k) % NM;
        if (bid[m_cand]) begin
          if (m_any < 0) m_any = m_cand;
          if (k < NM && m_oth < 0) m_oth = m_cand;
        end
      end
      m_pidle = m_idle;
      if (m_held != 0 && !m_usedn && m_obid && m_idle && m_cnt == LIM - 1) begin
        m_tag = "R10"; m_cnt = 0; m_used = 0;
        if (m_oth >= 0) begin m_own = m_oth; m_held = 1; end
        else m_held = 0;
      end else if ((m_held == 0 || !m_obid || m_usedn) && m_any >= 0) begin
        m_tag = "R4";
        m_used = (m_held != 0 && m_any == m_own) ? int'(m_usedn) : 0;
        m_own = m_any; m_held = 1; m_cnt = 0;
      end else if (m_held == 0 || !m_obid || m_usedn) begin
        m_tag = "R8"; m_used = int'(m_usedn); m_cnt = 0;
      end else begin
        m_tag = m_idle ? "R6" : "R11";
        if (m_idle) m_cnt = m_cnt + 1;
      end
    end
  end

  function automatic logic [NM-1:0] model_award();
    return (m_held != 0) ? (NM'(1) << m_own) : '0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (award !== model_award()) begin
        fails++;
        $display("FAIL %s cycle %0d award=%b expected=%b", m_tag, ncyc, award, model_award());
      end
      checks++;
      if (!$onehot0(award)) begin
        fails++;
        $display("FAIL R2 award=%b expected at most one bit", award);
      end
    end
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d expected finish", ncyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cyc(input logic [NM-1:0] b, input logic c, input logic x);
    bid = b; cycle_on = c; xfer_rdy = x;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [NM-1:0] exp, input string tag);
    checks++;
    if (award !== exp) begin
      fails++;
      $display("FAIL %s award=%b expected=%b", tag, award, exp);
    end
  endtask

  logic [NM-1:0] rb;

  initial begin
    repeat (3) @(negedge clk);
    chk('0, "R1 during reset");
    rst_n = 1'b1;
    cyc(4'b0000, 0, 0); chk(4'b0000, "R1 no request");
    cyc(4'b0000, 0, 0); chk(4'b0000, "R1 still none");
    cyc(4'b0100, 0, 0); chk(4'b0100, "R3 first grant");
    cyc(4'b1111, 0, 0); chk(4'b0100, "R6 fresh kept");
    cyc(4'b1111, 0, 0); chk(4'b0100, "R6 fresh kept 2");
    cyc(4'b1111, 1, 0); chk(4'b1000, "R5 hand over at start");
    for (int i = 0; i < 6; i++) begin
      cyc(4'b1111, 1, 1); chk(4'b1000, "R11 busy not counted");
    end
    cyc(4'b1111, 0, 1); chk(4'b1000, "R11 ready alone is busy");
    cyc(4'b1111, 0, 0); chk(4'b1000, "R6 waiting idle");
    cyc(4'b0111, 1, 0); chk(4'b0001, "R4 wrap to 0");
    cyc(4'b0111, 1, 1); chk(4'b0001, "R11 busy");
    cyc(4'b0111, 0, 1); chk(4'b0001, "R11 busy 2");
    cyc(4'b0111, 0, 0); chk(4'b0001, "R10 idle 1");
    cyc(4'b0111, 0, 0); chk(4'b0001, "R10 idle 2");
    cyc(4'b0111, 0, 0); chk(4'b0001, "R10 idle 3");
    cyc(4'b0111, 0, 0); chk(4'b0010, "R10 withdrawn to next");
    cyc(4'b0101, 0, 0); chk(4'b0100, "R7 owner dropped");
    for (int i = 0; i < 3; i++) begin
      cyc(4'b0000, 0, 0); chk(4'b0100, "R8 parked");
    end
    cyc(4'b0100, 0, 0); chk(4'b0100, "R10 wait 1");
    cyc(4'b0100, 0, 0); chk(4'b0100, "R10 wait 2");
    cyc(4'b0100, 0, 0); chk(4'b0100, "R10 wait 3");
    cyc(4'b0100, 0, 0); chk(4'b0000, "R10 withdrawn to none");
    cyc(4'b0100, 0, 0); chk(4'b0100, "R3 regranted");
    cyc(4'b0100, 1, 0); chk(4'b0100, "R9 sole requester keeps");
    cyc(4'b0100, 1, 1); chk(4'b0100, "R9 keeps busy");
    cyc(4'b0100, 1, 1); chk(4'b0100, "R9 keeps busy 2");
    cyc(4'b0110, 1, 1); chk(4'b0010, "R9 not protected, R2 direct");
    rb = '0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 == 0) rb = NM'($urandom);
      cyc(rb, ($urandom % 3) != 0, ($urandom % 2) == 0);
    end
    for (int i = 0; i < 1000; i++) begin
      if ($urandom % 8 == 0) rb = NM'($urandom);
      cyc(rb, ($urandom % 6) == 0, ($urandom % 8) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule